// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns one high-level flash request into the exact series of bus cycles that an asynchronous parallel NOR device expects. A client presents an operation code, a word address and a data word on a valid/ready port. The block then plays out the unlock, setup and command writes for that operation at fixed command addresses. Some operations read words back afterwards; those words are returned one at a time on a strobe. A single-cycle done pulse closes every operation.

The memory may be wired with an 8-bit or a 16-bit data bus. A configuration input picks the width, and the block scales every address it drives to match. Pin timing is kept simple: each access holds chip-enable and the relevant strobe low for a fixed number of clocks. Completion polling of the device, buffered programming and bank decoding are left to the surrounding logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` and `rsp_rd_valid` are 0, `mem_dq_oe` is 0, and `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1.
- R2: Op code 1 (program word) issues four writes: 0xAA to word 0x555, 0x55 to word 0x2AA, 0xA0 to word 0x555, and finally `req_data` to word `req_addr`.
- R3: Op code 2 (block erase) issues six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and then 0x30 to word `req_addr`.
- R4: Op code 3 (chip erase) issues the same first five writes as R3, and its sixth write is 0x10 to word 0x555.
- R5: Op code 4 (identify) writes 0xAA@0x555, 0x55@0x2AA and 0x90@0x555. It then reads words 0x000, 0x001, 0x00E and 0x00F in that order, and returns each word on `rsp_rd_data` with a one-cycle `rsp_rd_valid`.
- R6: Op code 5 (query) writes 0x98 to word 0x055. It then reads words 0x010 to 0x013 in ascending order and returns each one as in R5.
- R7: Op code 0 (back to read array) issues a single write of 0xF0 to word 0x000.
- R8: With `cfg_bus16`=1, `mem_addr` is twice the word address; with `cfg_bus16`=0 it equals the word address. `cfg_bus16` is sampled when a request is accepted, and changing it during an operation has no effect on that operation.
- R9: In 8-bit mode, write data bits [15:8] on `mem_dq_out` are driven 0. Returned read words carry 0 in bits [15:8].
- R10: Each access holds `mem_ce_n` low for exactly ACC_CLKS clocks. `mem_we_n` (write) or `mem_oe_n` (read), but not both, is low for the same clocks, and the address stays stable throughout. Consecutive accesses of one operation are separated by exactly one clock with `mem_ce_n` high. The first access starts one clock after acceptance, so done comes 1 + N·(ACC_CLKS+1) clocks after acceptance for an N-access operation.
- R11: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the clock after acceptance through the done cycle, so a request held during that time causes no bus access. `req_ready` returns to 1 the clock after done.
- R12: `rsp_done` is a single-cycle pulse. For op codes 4 and 5 it falls in the same cycle as the last `rsp_rd_valid`.
- R13: Op codes 6 and 7 are accepted, produce no bus access, and pulse done one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | 1 selects a 16-bit memory bus, 0 an 8-bit one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address for program or block erase |
| req_data | input | 16 | Data word for program |
| rsp_done | output | 1 | One-cycle end-of-operation pulse |
| rsp_rd_valid | output | 1 | A read word is on rsp_rd_data |
| rsp_rd_data | output | 16 | Returned read word |
| mem_addr | output | ADDR_W+1 | Memory bus address |
| mem_dq_out | output | 16 | Write data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Read data from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
Two events can share a cycle: the done pulse that closes an operation, and a new request waiting on the port. The bench holds a second request valid throughout the first operation. It then judges three things: the done cycle still shows ready low, no extra bus access appears, and the waiting request is taken exactly one clock after done. In the read operations, the strobe for the final word and the done pulse also coincide. The monitor checks that the two arrive on the same sampled cycle, and that the final word matches the memory model.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;

  localparam logic [2:0] OPC_READMODE = 3'd0;
  localparam logic [2:0] OPC_PROGRAM  = 3'd1;
  localparam logic [2:0] OPC_BLK_ERS  = 3'd2;
  localparam logic [2:0] OPC_CHIP_ERS = 3'd3;
  localparam logic [2:0] OPC_IDENT    = 3'd4;
  localparam logic [2:0] OPC_QUERY    = 3'd5;

  localparam int unsigned FIX_AW = 12;

  // One entry of an operation's bus script.
  typedef struct packed {
    logic              is_rd;
    logic              user_addr;
    logic              user_data;
    logic [FIX_AW-1:0] fix_addr;
    logic [7:0]        code;
  } step_t;

  function automatic logic [2:0] seq_len(input logic [2:0] op);
    case (op)
      OPC_READMODE: seq_len = 3'd1;
      OPC_PROGRAM:  seq_len = 3'd4;
      OPC_BLK_ERS:  seq_len = 3'd6;
      OPC_CHIP_ERS: seq_len = 3'd6;
      OPC_IDENT:    seq_len = 3'd7;
      OPC_QUERY:    seq_len = 3'd5;
      default:      seq_len = 3'd0;
    endcase
  endfunction

  function automatic step_t wr_fix(input logic [FIX_AW-1:0] a, input logic [7:0] c);
    step_t s;
    s = '0;
    s.fix_addr = a;
    s.code = c;
    return s;
  endfunction

  function automatic step_t rd_fix(input logic [FIX_AW-1:0] a);
    step_t s;
    s = '0;
    s.is_rd = 1'b1;
    s.fix_addr = a;
    return s;
  endfunction

  // First two writes of every unlocked command, also repeated in erase.
  function automatic step_t unlock_pair(input logic second);
    return second ? wr_fix(12'h2AA, 8'h55) : wr_fix(12'h555, 8'hAA);
  endfunction

  function automatic step_t seq_step(input logic [2:0] op, input logic [2:0] idx);
    step_t s;
    s = '0;
    case (op)
      OPC_READMODE: s = wr_fix(12'h000, 8'hF0);
      OPC_PROGRAM: begin
        case (idx)
          3'd0, 3'd1: s = unlock_pair(idx[0]);
          3'd2:       s = wr_fix(12'h555, 8'hA0);
          default: begin
            s.user_addr = 1'b1;
            s.user_data = 1'b1;
          end
        endcase
      end
      OPC_BLK_ERS, OPC_CHIP_ERS: begin
        case (idx)
          3'd0, 3'd1: s = unlock_pair(idx[0]);
          3'd2:       s = wr_fix(12'h555, 8'h80);
          3'd3:       s = unlock_pair(1'b0);
          3'd4:       s = unlock_pair(1'b1);
          default: begin
            if (op == OPC_BLK_ERS) begin
              s.user_addr = 1'b1;
              s.code = 8'h30;
            end else begin
              s = wr_fix(12'h555, 8'h10);
            end
          end
        endcase
      end
      OPC_IDENT: begin
        case (idx)
          3'd0, 3'd1: s = unlock_pair(idx[0]);
          3'd2:       s = wr_fix(12'h555, 8'h90);
          3'd3:       s = rd_fix(12'h000);
          3'd4:       s = rd_fix(12'h001);
          3'd5:       s = rd_fix(12'h00E);
          default:    s = rd_fix(12'h00F);
        endcase
      end
      OPC_QUERY: begin
        if (idx == 3'd0) s = wr_fix(12'h055, 8'h98);
        else             s = rd_fix(12'h00F + FIX_AW'(idx));
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nor_step_table.sv
`timescale 1ns/1ps
module nor_step_table #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [2:0]        op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] user_addr,
  input  logic [15:0]       user_data,
  output logic [2:0]        op_len,
  output logic              st_rd,
  output logic [ADDR_W-1:0] st_addr,
  output logic [15:0]       st_data
);
  import nor_seq_pkg::*;

  step_t cur;
  logic [ADDR_W-1:0] fix_ext;

  assign cur    = seq_step(op, idx);
  assign op_len = seq_len(op);

  generate
    if (ADDR_W >= FIX_AW) begin : g_wide_addr
      assign fix_ext = {{(ADDR_W-FIX_AW){1'b0}}, cur.fix_addr};
    end else begin : g_narrow_addr
      assign fix_ext = cur.fix_addr[ADDR_W-1:0];
    end
  endgenerate

  assign st_rd   = cur.is_rd;
  assign st_addr = cur.user_addr ? user_addr : fix_ext;
  assign st_data = cur.user_data ? user_data : {8'h00, cur.code};
endmodule

// File: rtl/nor_bus_phy.sv
`timescale 1ns/1ps
module nor_bus_phy #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned ACC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_waddr,
  input  logic [15:0]       acc_wdata,
  input  logic              bus16,
  output logic              acc_ready,
  output logic              acc_end,
  output logic              rd_strobe,
  output logic [15:0]       rd_word,
  output logic [ADDR_W:0]   mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int unsigned CW = (ACC_CLKS > 1) ? $clog2(ACC_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACC_CLKS - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_DRIVE, PH_REST} ph_e;

  ph_e             ph;
  logic [CW-1:0]   cnt;
  logic            rd_q;
  logic [ADDR_W:0] addr_q;
  logic [15:0]     data_q;
  logic [15:0]     rdw_q;

  function automatic logic [ADDR_W:0] bus_addr(input logic [ADDR_W-1:0] w, input logic wide);
    return wide ? {w, 1'b0} : {1'b0, w};
  endfunction

  function automatic logic [15:0] fit_lane(input logic [15:0] d, input logic wide);
    return wide ? d : {8'h00, d[7:0]};
  endfunction

  assign acc_ready = (ph == PH_IDLE) || (ph == PH_REST);
  assign acc_end   = (ph == PH_REST);
  assign rd_strobe = (ph == PH_REST) && rd_q;
  assign rd_word   = rdw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdw_q  <= '0;
    end else begin
      case (ph)
        PH_IDLE, PH_REST: begin
          if (go) begin
            ph     <= PH_DRIVE;
            cnt    <= CNT_LOAD;
            rd_q   <= acc_rd;
            addr_q <= bus_addr(acc_waddr, bus16);
            data_q <= fit_lane(acc_wdata, bus16);
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_DRIVE: begin
          if (cnt == '0) begin
            ph <= PH_REST;
            if (rd_q) rdw_q <= fit_lane(mem_dq_in, bus16);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;
  assign mem_ce_n   = !(ph == PH_DRIVE);
  assign mem_we_n   = !((ph == PH_DRIVE) && !rd_q);
  assign mem_oe_n   = !((ph == PH_DRIVE) && rd_q);
  assign mem_dq_oe  = (ph == PH_DRIVE) && !rd_q;

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_we_n ^ mem_oe_n));
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned ACC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus16,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  output logic              rsp_done,
  output logic              rsp_rd_valid,
  output logic [15:0]       rsp_rd_data,
  output logic [ADDR_W:0]   mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  typedef enum logic {T_IDLE, T_RUN} top_e;

  top_e              state;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] uaddr_q;
  logic [15:0]       udata_q;
  logic              bus16_q;
  logic [2:0]        step_q;

  logic [2:0]        op_len;
  logic              st_rd;
  logic [ADDR_W-1:0] st_addr;
  logic [15:0]       st_data;

  logic acc_ready, acc_end, rd_strobe;
  logic [15:0] rd_word;

  // Named internal events
  logic take_req;
  logic issue_go;
  logic script_spent;
  logic op_finish;

  assign req_ready    = (state == T_IDLE);
  assign take_req     = req_valid && req_ready;
  assign script_spent = (step_q == op_len);
  assign issue_go     = (state == T_RUN) && acc_ready && !script_spent;
  assign op_finish    = (state == T_RUN) && script_spent && (acc_end || (op_len == 3'd0));

  nor_step_table #(.ADDR_W(ADDR_W)) table_i (
    .op        (op_q),
    .idx       (step_q),
    .user_addr (uaddr_q),
    .user_data (udata_q),
    .op_len    (op_len),
    .st_rd     (st_rd),
    .st_addr   (st_addr),
    .st_data   (st_data)
  );

  nor_bus_phy #(.ADDR_W(ADDR_W), .ACC_CLKS(ACC_CLKS)) phy_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (issue_go),
    .acc_rd     (st_rd),
    .acc_waddr  (st_addr),
    .acc_wdata  (st_data),
    .bus16      (bus16_q),
    .acc_ready  (acc_ready),
    .acc_end    (acc_end),
    .rd_strobe  (rd_strobe),
    .rd_word    (rd_word),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= T_IDLE;
      op_q    <= '0;
      uaddr_q <= '0;
      udata_q <= '0;
      bus16_q <= 1'b0;
      step_q  <= '0;
    end else begin
      case (state)
        T_IDLE: begin
          if (take_req) begin
            state   <= T_RUN;
            op_q    <= req_op;
            uaddr_q <= req_addr;
            udata_q <= req_data;
            bus16_q <= cfg_bus16;
            step_q  <= '0;
          end
        end
        default: begin
          if (issue_go) step_q <= step_q + 1'b1;
          if (op_finish) state <= T_IDLE;
        end
      endcase
    end
  end

  assign rsp_done     = op_finish;
  assign rsp_rd_valid = rd_strobe;
  assign rsp_rd_data  = rd_word;

  a_r11_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !req_ready);
  a_r11_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);
  a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r8_width_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(bus16_q));
  a_r9_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus16_q && mem_dq_oe) |-> (mem_dq_out[15:8] == 8'h00));
endmodule

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
  localparam int AW  = 20;
  localparam int ACC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_bus16 = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_data = '0;
  logic          rsp_done, rsp_rd_valid;
  logic [15:0]   rsp_rd_data;
  logic [AW:0]   mem_addr;
  logic [15:0]   mem_dq_out, mem_dq_in;
  logic          mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;

  function automatic logic [15:0] rdmodel(input logic [AW:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h11};
  endfunction

  assign mem_dq_in = rdmodel(mem_addr);

  nor_cmd_seq #(.ADDR_W(AW), .ACC_CLKS(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_done(rsp_done), .rsp_rd_valid(rsp_rd_valid), .rsp_rd_data(rsp_rd_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;
  string cur_tag = "R1";
  bit op_is_read = 0;
  int op_seq = 0;

  typedef struct packed {
    logic        rd;
    logic [AW:0] a;
    logic [15:0] d;
  } acc_t;

  acc_t        exp_q[$];
  logic [15:0] rdexp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [AW:0] phys(input logic [AW-1:0] wa, input bit b16);
    logic [AW:0] w;
    w = {1'b0, wa};
    return b16 ? w * 2 : w;
  endfunction

  task automatic push_w(input logic [AW-1:0] wa, input logic [15:0] d, input bit b16);
    acc_t e;
    e.rd = 1'b0;
    e.a  = phys(wa, b16);
    e.d  = b16 ? d : (d & 16'h00FF);
    exp_q.push_back(e);
  endtask

  task automatic push_r(input logic [AW-1:0] wa, input bit b16);
    acc_t e;
    logic [15:0] v;
    e.rd = 1'b1;
    e.a  = phys(wa, b16);
    e.d  = '0;
    exp_q.push_back(e);
    v = rdmodel(e.a);
    rdexp_q.push_back(b16 ? v : (v & 16'h00FF));
  endtask

  task automatic push_unlock(input bit b16);
    push_w(20'h555, 16'h00AA, b16);
    push_w(20'h2AA, 16'h0055, b16);
  endtask

  task automatic push_seq(input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [15:0] d, input bit b16);
    case (op)
      3'd0: push_w(20'h000, 16'h00F0, b16);
      3'd1: begin
        push_unlock(b16);
        push_w(20'h555, 16'h00A0, b16);
        push_w(a, d, b16);
      end
      3'd2, 3'd3: begin
        push_unlock(b16);
        push_w(20'h555, 16'h0080, b16);
        push_unlock(b16);
        if (op == 3'd2) push_w(a, 16'h0030, b16);
        else            push_w(20'h555, 16'h0010, b16);
      end
      3'd4: begin
        push_unlock(b16);
        push_w(20'h555, 16'h0090, b16);
        push_r(20'h000, b16);
        push_r(20'h001, b16);
        push_r(20'h00E, b16);
        push_r(20'h00F, b16);
      end
      3'd5: begin
        push_w(20'h055, 16'h0098, b16);
        for (int i = 0; i < 4; i++) push_r(AW'(16 + i), b16);
      end
      default: ;
    endcase
  endtask

  task automatic wait_done(input int n_acc, input string tag);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rsp_done && k < 4000);
    chk(k == 1 + n_acc * (ACC + 1), "R10", {tag, " done latency"}, k, 1 + n_acc * (ACC + 1));
  endtask

  task automatic check_drained(input string tag);
    @(negedge clk);
    chk(exp_q.size() == 0, tag, "bus accesses missing", exp_q.size(), 0);
    chk(rdexp_q.size() == 0, tag, "read words missing", rdexp_q.size(), 0);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                        input bit b16, input bit flip, input string tag);
    int n0, n;
    n0 = exp_q.size();
    push_seq(op, a, d, b16);
    n = exp_q.size() - n0;
    @(negedge clk);
    cur_tag = tag;
    op_is_read = (op == 3'd4) || (op == 3'd5);
    cfg_bus16 = b16;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    op_seq++;
    if (flip) cfg_bus16 = ~b16;
    wait_done(n, tag);
    check_drained(tag);
  endtask

  // Second request is held valid during the first operation.
  task automatic run_pair(input logic [2:0] opa, input logic [AW-1:0] aa, input logic [15:0] da,
                          input logic [2:0] opb, input logic [AW-1:0] ab, input logic [15:0] db,
                          input bit b16);
    int n0, na, nb;
    n0 = exp_q.size();
    push_seq(opa, aa, da, b16);
    na = exp_q.size() - n0;
    n0 = exp_q.size();
    push_seq(opb, ab, db, b16);
    nb = exp_q.size() - n0;
    @(negedge clk);
    cur_tag = "R11";
    op_is_read = (opa == 3'd4) || (opa == 3'd5);
    cfg_bus16 = b16;
    req_op = opa; req_addr = aa; req_data = da; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    op_seq++;
    req_op = opb; req_addr = ab; req_data = db;
    wait_done(na, "R11 first");
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready one clock after done", req_ready, 1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    op_seq++;
    op_is_read = (opb == 3'd4) || (opb == 3'd5);
    wait_done(nb, "R11 second");
    check_drained("R11");
  endtask

  // Monitor: pops the scoreboard as the bus and response ports produce results.
  logic prev_ce = 1'b1;
  logic prev_done = 1'b0;
  int   lowc = 0;
  int   gapc = 0;
  int   mon_seq = 0;
  acc_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        if (prev_ce) begin
          if (mon_seq == op_seq) chk(gapc == 1, "R10", "idle clocks between accesses", gapc, 1);
          mon_seq = op_seq;
          lowc = 1;
          cur.rd = !mem_oe_n;
          cur.a  = mem_addr;
          cur.d  = mem_dq_out;
          chk((mem_we_n == cur.rd) && (mem_dq_oe == !cur.rd), "R10", "strobe pattern",
              {mem_we_n, mem_oe_n, mem_dq_oe}, {cur.rd, !cur.rd, !cur.rd});
        end else begin
          lowc++;
          if (mem_addr != cur.a) chk(1'b0, "R10", "address moved in access", mem_addr, cur.a);
        end
      end else begin
        if (!prev_ce) begin
          chk(lowc == ACC, "R10", "access width", lowc, ACC);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected bus access", cur.a, 0);
          end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk(e.rd == cur.rd, cur_tag, "access kind", cur.rd, e.rd);
            chk(e.a == cur.a, "R8", {cur_tag, " bus address"}, cur.a, e.a);
            if (!e.rd) chk(e.d == cur.d, cur_tag, "write data", cur.d, e.d);
          end
          gapc = 1;
        end else begin
          gapc++;
        end
      end
      prev_ce = mem_ce_n;
      if (rsp_rd_valid) begin
        if (rdexp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected read word", rsp_rd_data, 0);
        end else begin
          logic [15:0] ev;
          ev = rdexp_q.pop_front();
          chk(rsp_rd_data == ev, cur_tag, "read word", rsp_rd_data, ev);
        end
      end
      if (rsp_done) begin
        chk(!req_ready, "R11", "ready during done", req_ready, 0);
        if (op_is_read) chk(rsp_rd_valid, "R12", "last word with done", rsp_rd_valid, 1);
        chk(!prev_done, "R12", "done width", prev_done, 0);
      end
      prev_done = rsp_done;
    end
  end

  initial begin
    #3_000_000;
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1", "strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk({rsp_done, rsp_rd_valid, mem_dq_oe} == 3'b000, "R1", "outputs in reset",
        {rsp_done, rsp_rd_valid, mem_dq_oe}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    run_op(3'd1, 20'h12345, 16'hBEEF, 1, 0, "R2");
    run_op(3'd1, 20'h0ABCD, 16'hBEEF, 0, 0, "R9");
    run_op(3'd2, 20'h40000, 16'h0000, 1, 0, "R3");
    run_op(3'd3, 20'h00000, 16'h0000, 0, 0, "R4");
    run_op(3'd3, 20'h00000, 16'h0000, 1, 0, "R4");
    run_op(3'd4, 20'h00000, 16'h0000, 1, 0, "R5");
    run_op(3'd4, 20'h00000, 16'h0000, 0, 0, "R9");
    run_op(3'd5, 20'h00000, 16'h0000, 1, 0, "R6");
    run_op(3'd5, 20'h00000, 16'h0000, 0, 0, "R6");
    run_op(3'd0, 20'h00000, 16'h0000, 1, 0, "R7");
    run_op(3'd6, 20'h00123, 16'h5555, 1, 0, "R13");
    run_op(3'd7, 20'h00456, 16'hAAAA, 0, 0, "R13");
    run_op(3'd2, 20'h7F000, 16'h0000, 1, 1, "R8");
    run_op(3'd1, 20'h00321, 16'hC3A5, 0, 1, "R8");
    run_pair(3'd1, 20'h00100, 16'h1234, 3'd5, 20'h00000, 16'h0000, 1);
    run_pair(3'd4, 20'h00000, 16'h0000, 3'd6, 20'h00000, 16'h0000, 0);

    finish_run();
  end
endmodule